// File: doc/BRIEF.md
# DRAM Write Cycle Sequencer

This block runs a single 16-bit early-write cycle on an asynchronous DRAM. A host pulses a request together with a row address, a column address, a data word and a 16-bit control word. The sequencer puts the row on the multiplexed address bus and drops RAS. It then switches the bus to the column and drops CAS. After CAS it releases RAS and waits out the precharge time. Write-enable and the data-out bus are active from before RAS falls until RAS rises. Output-enable is never asserted, because the block only writes.

Each phase length is a whole number of clocks and comes from three fields of the control word. Bit 5 selects a slow address multiplex and lengthens the RAS-to-CAS delay. Bit 3 selects slow RAS timing, which changes both the minimum RAS low time and the precharge length. Bits 13:12 set the CAS low width. These fields are captured when a request is accepted and stay fixed until the cycle ends. The block reports busy while it works and gives a one-clock done at the end of precharge. It accepts a new request in the clock in which done is high.

Top module: `dram_wr_seq`

## Requirements
- R1: While reset is low, ras_n, cas_n, we_n and oe_n are high, and busy, done and dq_oe are low.
- R2: The row address is on addr for ROW_SETUP clocks (default 2) before RAS falls and for 1 clock after it falls. After that the column address stays on addr until RAS rises.
- R3: CAS falls 2 clocks after RAS falls when control bit 5 is 0, and 3 clocks after when it is 1. In both cases CAS falls only while RAS is low.
- R4: CAS stays low for 1, 2, 3 or 4 clocks when control bits 13:12 are 00, 01, 10 or 11.
- R5: RAS rises at least 1 clock after CAS rises. If the RAS low time would otherwise be shorter than the minimum, the gap grows until the minimum is met. The minimum is RAS_MIN_FAST clocks (default 3) when control bit 3 is 0 and RAS_MIN_SLOW clocks (default 4) when it is 1.
- R6: we_n is low and dq_oe is high, with the captured data on dq_out, from the first row-setup clock until RAS rises. oe_n stays high at all times.
- R7: After RAS rises, RAS stays high for 2 clocks of precharge (control bit 3 = 0) or 4 clocks (bit 3 = 1). done is then high for exactly one clock. busy is high from the clock after acceptance up to that done clock, and low in the done clock.
- R8: A request that arrives while busy is high is ignored. No second cycle follows, and the address and data of the running cycle do not change.
- R9: A change on the control word while busy is high does not affect the timing of the running cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Write request; accepted only while idle |
| cfg_word | input | 16 | Control word: bit 5 slow multiplex, bit 3 slow RAS, bits 13:12 CAS width |
| row_addr | input | AW | Row address |
| col_addr | input | AW | Column address |
| wdata | input | DW | Write data |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-clock pulse at the end of precharge |
| addr | output | AW | Multiplexed DRAM address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low (held high) |
| dq_out | output | DW | Write data bus |
| dq_oe | output | 1 | Drive enable for dq_out |

## Verification
The assertions assume that reset is held low across at least one clock edge before the first request. They also assume that the control word, addresses and data are only meaningful in the clock in which req is accepted. The stimulus changes every input only at falling clock edges. During some cycles it deliberately drives a second request, a different address and a different control word while busy is high. All four control settings that affect timing are covered, both by random draws from a fixed seed and by directed extreme cases. The bench sets the slow RAS minimum above the CAS-derived length, so the stretch rule in R5 is exercised.

// File: rtl/dram_wr_pkg.sv
`timescale 1ns/1ps
package dram_wr_pkg;
    localparam int MUX_SLOW_BIT = 5;
    localparam int RAS_SLOW_BIT = 3;
    localparam int CAS_SEL_LSB  = 12;

    typedef enum logic [2:0] {
        PH_IDLE, PH_ROWSET, PH_ROWHOLD, PH_COLSET, PH_CASLO, PH_TAIL, PH_PRECH
    } phase_e;

    typedef struct packed {
        logic       mux_slow;
        logic       ras_slow;
        logic [1:0] cas_sel;
    } timing_cfg_t;
endpackage

// File: rtl/dram_wr_timing.sv
`timescale 1ns/1ps
module dram_wr_timing
    import dram_wr_pkg::*;
#(
    parameter int CNT_W        = 4,
    parameter int ROW_HOLD     = 1,
    parameter int RAS_MIN_FAST = 3,
    parameter int RAS_MIN_SLOW = 4,
    parameter int PRE_FAST     = 2,
    parameter int PRE_SLOW     = 4
) (
    input  timing_cfg_t      cfg,
    output logic [CNT_W-1:0] hold_len,
    output logic [CNT_W-1:0] colset_len,
    output logic [CNT_W-1:0] cas_len,
    output logic [CNT_W-1:0] tail_len,
    output logic [CNT_W-1:0] pre_len
);
    localparam int SUM_W = CNT_W + 2;

    logic [SUM_W-1:0] used;
    logic [SUM_W-1:0] ras_min;

    always_comb begin
        hold_len   = CNT_W'(ROW_HOLD);
        colset_len = cfg.mux_slow ? CNT_W'(2) : CNT_W'(1);
        cas_len    = CNT_W'({2'b00, cfg.cas_sel}) + CNT_W'(1);
        pre_len    = cfg.ras_slow ? CNT_W'(PRE_SLOW) : CNT_W'(PRE_FAST);
        ras_min    = cfg.ras_slow ? SUM_W'(RAS_MIN_SLOW) : SUM_W'(RAS_MIN_FAST);
        used       = SUM_W'(hold_len) + SUM_W'(colset_len) + SUM_W'(cas_len);
        if (ras_min > used + SUM_W'(1))
            tail_len = CNT_W'(ras_min - used);
        else
            tail_len = CNT_W'(1);
    end
endmodule

// File: rtl/dram_wr_ctrl.sv
`timescale 1ns/1ps
module dram_wr_ctrl
    import dram_wr_pkg::*;
#(
    parameter int AW        = 12,
    parameter int DW        = 16,
    parameter int CNT_W     = 4,
    parameter int ROW_SETUP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [15:0]      cfg_word,
    input  logic [AW-1:0]    row_addr,
    input  logic [AW-1:0]    col_addr,
    input  logic [DW-1:0]    wdata,
    input  logic [CNT_W-1:0] hold_len,
    input  logic [CNT_W-1:0] colset_len,
    input  logic [CNT_W-1:0] cas_len,
    input  logic [CNT_W-1:0] tail_len,
    input  logic [CNT_W-1:0] pre_len,
    output timing_cfg_t      cfg_cur,
    output logic             busy,
    output logic             done,
    output logic [AW-1:0]    addr,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [DW-1:0]    dq_out,
    output logic             dq_oe
);
    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  cnt;
        timing_cfg_t       cfg;
        logic [AW-1:0]     row;
        logic [AW-1:0]     col;
        logic [DW-1:0]     data;
        logic [AW-1:0]     addr;
        logic              done;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic              dq_oe;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end else begin
            unique case (st_q.ph)
                PH_IDLE: if (req) begin
                    st_d.ph  = PH_ROWSET;
                    st_d.cnt = CNT_W'(ROW_SETUP - 1);
                    st_d.cfg.mux_slow = cfg_word[MUX_SLOW_BIT];
                    st_d.cfg.ras_slow = cfg_word[RAS_SLOW_BIT];
                    st_d.cfg.cas_sel  = cfg_word[CAS_SEL_LSB+1:CAS_SEL_LSB];
                    st_d.row  = row_addr;
                    st_d.col  = col_addr;
                    st_d.data = wdata;
                end
                PH_ROWSET:  begin st_d.ph = PH_ROWHOLD; st_d.cnt = hold_len - CNT_W'(1);   end
                PH_ROWHOLD: begin st_d.ph = PH_COLSET;  st_d.cnt = colset_len - CNT_W'(1); end
                PH_COLSET:  begin st_d.ph = PH_CASLO;   st_d.cnt = cas_len - CNT_W'(1);    end
                PH_CASLO:   begin st_d.ph = PH_TAIL;    st_d.cnt = tail_len - CNT_W'(1);   end
                PH_TAIL:    begin st_d.ph = PH_PRECH;   st_d.cnt = pre_len - CNT_W'(1);    end
                PH_PRECH:   begin st_d.ph = PH_IDLE;    st_d.done = 1'b1;                 end
                default:    st_d.ph = PH_IDLE;
            endcase
        end

        st_d.ras_n = !(st_d.ph inside {PH_ROWHOLD, PH_COLSET, PH_CASLO, PH_TAIL});
        st_d.cas_n = (st_d.ph != PH_CASLO);
        st_d.dq_oe = st_d.ph inside {PH_ROWSET, PH_ROWHOLD, PH_COLSET, PH_CASLO, PH_TAIL};
        st_d.we_n  = !st_d.dq_oe;
        if (st_d.ph inside {PH_ROWSET, PH_ROWHOLD})
            st_d.addr = st_d.row;
        else if (st_d.ph inside {PH_COLSET, PH_CASLO, PH_TAIL})
            st_d.addr = st_d.col;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.ph    <= PH_IDLE;
            st_q.ras_n <= 1'b1;
            st_q.cas_n <= 1'b1;
            st_q.we_n  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_cur = st_q.cfg;
    assign busy    = (st_q.ph != PH_IDLE);
    assign done    = st_q.done;
    assign addr    = st_q.addr;
    assign ras_n   = st_q.ras_n;
    assign cas_n   = st_q.cas_n;
    assign we_n    = st_q.we_n;
    assign dq_out  = st_q.data;
    assign dq_oe   = st_q.dq_oe;

    // R3: CAS only ever falls inside a RAS low period
    assert_cas_in_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);
    // R4: the column address does not move while CAS is low
    assert_col_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && $past(!cas_n)) |-> $stable(addr));
    // R5: CAS is already high in the clock before RAS rises
    assert_ras_after_cas_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> $past(cas_n));
    // R6: write enable and data drive are active before CAS falls
    assert_we_lead_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> ($past(!we_n) && $past(dq_oe)));
    // R7: done lasts one clock and is never seen together with busy
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R8: captured row and column do not change during a cycle
    assert_hold_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(st_q.row) && $stable(st_q.col) && $stable(dq_out)));
    // R9: captured timing fields hold for the whole cycle
    assert_cfg_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cfg_cur));
endmodule

// File: rtl/dram_wr_seq.sv
`timescale 1ns/1ps
module dram_wr_seq
    import dram_wr_pkg::*;
#(
    parameter int AW           = 12,
    parameter int DW           = 16,
    parameter int CNT_W        = 4,
    parameter int ROW_SETUP    = 2,
    parameter int ROW_HOLD     = 1,
    parameter int RAS_MIN_FAST = 3,
    parameter int RAS_MIN_SLOW = 4,
    parameter int PRE_FAST     = 2,
    parameter int PRE_SLOW     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [15:0]   cfg_word,
    input  logic [AW-1:0] row_addr,
    input  logic [AW-1:0] col_addr,
    input  logic [DW-1:0] wdata,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] addr,
    output logic          ras_n,
    output logic          cas_n,
    output logic          we_n,
    output logic          oe_n,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe
);
    timing_cfg_t      cfg_cur;
    logic [CNT_W-1:0] hold_len, colset_len, cas_len, tail_len, pre_len;

    dram_wr_timing #(
        .CNT_W(CNT_W), .ROW_HOLD(ROW_HOLD),
        .RAS_MIN_FAST(RAS_MIN_FAST), .RAS_MIN_SLOW(RAS_MIN_SLOW),
        .PRE_FAST(PRE_FAST), .PRE_SLOW(PRE_SLOW)
    ) u_timing (
        .cfg(cfg_cur), .hold_len(hold_len), .colset_len(colset_len),
        .cas_len(cas_len), .tail_len(tail_len), .pre_len(pre_len)
    );

    dram_wr_ctrl #(
        .AW(AW), .DW(DW), .CNT_W(CNT_W), .ROW_SETUP(ROW_SETUP)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .cfg_word(cfg_word),
        .row_addr(row_addr), .col_addr(col_addr), .wdata(wdata),
        .hold_len(hold_len), .colset_len(colset_len), .cas_len(cas_len),
        .tail_len(tail_len), .pre_len(pre_len), .cfg_cur(cfg_cur),
        .busy(busy), .done(done), .addr(addr), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // R6: a write-only sequencer never enables the DRAM outputs
    assign oe_n = 1'b1;
endmodule

// File: tb/dram_wr_seq_test.sv
`timescale 1ns/1ps
module dram_wr_seq_test;
    localparam int AW = 12;
    localparam int DW = 16;
    localparam int RMIN_F = 3;
    localparam int RMIN_S = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req;
    logic [15:0]   cfg_word;
    logic [AW-1:0] row_addr, col_addr;
    logic [DW-1:0] wdata;
    logic          busy, done, ras_n, cas_n, we_n, oe_n, dq_oe;
    logic [AW-1:0] addr;
    logic [DW-1:0] dq_out;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dram_wr_seq #(.AW(AW), .DW(DW), .RAS_MIN_SLOW(RMIN_S)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .cfg_word(cfg_word),
        .row_addr(row_addr), .col_addr(col_addr), .wdata(wdata),
        .busy(busy), .done(done), .addr(addr), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .oe_n(oe_n), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // phase lengths: rowset, rowhold, colset, caslo, tail, precharge
    function automatic int plen(input int p, input bit m, input bit s, input int bc);
        int used;
        int rmin;
        used = 1 + (m ? 2 : 1) + (bc + 1);
        rmin = s ? RMIN_S : RMIN_F;
        case (p)
            0: return 2;
            1: return 1;
            2: return m ? 2 : 1;
            3: return bc + 1;
            4: return (rmin > used + 1) ? rmin - used : 1;
            default: return s ? 4 : 2;
        endcase
    endfunction

    // phase index 1..6 for trace cycle i, 0 once the cycle is over
    function automatic int exp_phase(input int i, input bit m, input bit s, input int bc);
        int acc = 0;
        for (int p = 0; p < 6; p++) begin
            acc += plen(p, m, s, bc);
            if (i < acc) return p + 1;
        end
        return 0;
    endfunction

    task automatic run_txn(input logic [15:0] cw, input logic [AW-1:0] r,
                           input logic [AW-1:0] c, input logic [DW-1:0] d,
                           input bit inject, input bit flip);
        bit m, s;
        int bc, total, ph;
        string pre;
        m  = cw[5];
        s  = cw[3];
        bc = int'(cw[13:12]);
        total = 0;
        for (int p = 0; p < 6; p++) total += plen(p, m, s, bc);
        pre = flip ? "R9 " : (inject ? "R8 " : "");
        req = 1'b1; cfg_word = cw; row_addr = r; col_addr = c; wdata = d;
        for (int i = 0; i <= total; i++) begin
            @(negedge clk);
            if (i == 0) begin
                req = inject;
                if (inject) begin row_addr = ~r; col_addr = ~c; wdata = ~d; end
                if (flip) cfg_word = ~cw;
            end
            ph = exp_phase(i, m, s, bc);
            check({pre, "R7 busy"}, busy, (i < total));
            check({pre, "R7 done"}, done, (i == total));
            check({pre, "R5 ras_n"}, ras_n, !(ph >= 2 && ph <= 5));
            check({pre, "R3 R4 cas_n"}, cas_n, (ph != 4));
            check({pre, "R6 we_n"}, we_n, !(ph >= 1 && ph <= 5));
            check({pre, "R6 dq_oe"}, dq_oe, (ph >= 1 && ph <= 5));
            check({pre, "R6 oe_n"}, oe_n, 1'b1);
            if (ph >= 1 && ph <= 5) check({pre, "R6 dq_out"}, dq_out, d);
            if (ph == 1 || ph == 2) check({pre, "R2 row addr"}, addr, r);
            if (ph >= 3 && ph <= 5) check({pre, "R2 col addr"}, addr, c);
            if (i == total) req = 1'b0;
        end
        if (inject) begin
            // R8: the request seen while busy must not start a second cycle
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                check("R8 idle ras_n", ras_n, 1'b1);
                check("R8 idle busy", busy, 1'b0);
            end
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        rst_n = 1'b0; req = 1'b0; cfg_word = '0; row_addr = '0; col_addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ras_n", ras_n, 1'b1);
        check("R1 cas_n", cas_n, 1'b1);
        check("R1 we_n", we_n, 1'b1);
        check("R1 oe_n", oe_n, 1'b1);
        check("R1 busy", busy, 1'b0);
        check("R1 done", done, 1'b0);
        check("R1 dq_oe", dq_oe, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corners: fastest, slowest, RAS minimum stretching the tail
        run_txn(16'h0000, 12'h123, 12'h456, 16'hA5A5, 0, 0);
        run_txn(16'h3028, 12'hFFF, 12'h000, 16'h0000, 0, 0);
        run_txn(16'h0008, 12'h001, 12'hFFE, 16'hFFFF, 0, 0);
        run_txn(16'h1008, 12'h2AA, 12'h155, 16'h1234, 0, 0);
        run_txn(16'h2020, 12'h0F0, 12'h70F, 16'hBEEF, 1, 0);
        run_txn(16'h0000, 12'h333, 12'h444, 16'hC0DE, 0, 1);
        run_txn(16'h3028, 12'h555, 12'h666, 16'h0F0F, 0, 1);

        for (int t = 0; t < 40; t++) begin
            logic [15:0] cw;
            cw = 16'($urandom);
            run_txn(cw, AW'($urandom), AW'($urandom), DW'($urandom),
                    ($urandom % 4) == 0, ($urandom % 4) == 1);
            if ($urandom % 2) begin
                @(negedge clk);
                check("R7 idle busy", busy, 1'b0);
            end
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule